// File: doc/BRIEF.md
# EEPROM Write Guard and Page Programming Controller

This block decides whether a write request from a serial front-end may reach a small byte-addressed non-volatile array, and if so, how. It holds a write-enable latch and a two-bit block-guard field. It collects up to one page of data in a buffer. When the chip-select line is released, it launches a self-timed programming cycle. The front-end decodes commands and data bytes and hands them over as single-cycle strobes on the system clock, along with the live levels of chip-select and the write-protect pin.

A write is allowed only when four conditions all hold: the enable latch is set, the write-protect pin is high, the target page lies outside the guarded region, and the command was not disturbed by write-protect during its frame. During the cycle the block streams the buffered bytes to the array, one per clock. It raises busy for a fixed number of clocks derived from the clock rate and a programming-time parameter. At the end it drops the enable latch. A status-register write uses the same cycle and applies the new guard field when the cycle ends.

Top module: `eeprom_wr_ctrl`

## Requirements
- R1: After reset, `status` is 8'h00, `busy` is 0 and `arr_we` is 0.
- R2: `status` bit 0 is busy, bit 1 is the enable latch, bits 3:2 are the guard field, and bits 7:4 are 0. Command codes on `cmd_op` are: 0 read, 1 page write, 2 set latch, 3 clear latch, 4 status read, 5 status write. Code 2 sets the latch and code 3 clears it.
- R3: A page write issued while the latch is clear starts no cycle and drives no array write.
- R4: A page write or status write issued while `wp_n` is low starts no cycle, and leaves the array and the guard field unchanged.
- R5: The guard field selects the blocked region. 00 blocks nothing, 01 blocks addresses 384 and up, 10 blocks addresses 256 and up, and 11 blocks the whole array. A page write whose start address is blocked starts no cycle.
- R6: Bytes of a page write fill the page from the start offset and wrap to offset 0 of the same page. A later byte overwrites an earlier byte at the same offset. During the cycle, each loaded offset is written once, in ascending offset order, on busy clock number equal to the offset (counting from 0). Offsets that were never loaded are not written.
- R7: A cycle starts on the first clock edge that sees `cs_n` high after an accepted frame. Busy then stays high for CLK_KHZ*min(WC_US,10000)/1000 clocks, with a minimum of the page size.
- R8: If `wp_n` is low in any cycle of an open write frame, that frame starts no cycle, even if `wp_n` is high again when `cs_n` rises.
- R9: Once a cycle has started, `wp_n` has no effect on it: all loaded bytes are written and busy lasts the full time.
- R10: The latch clears at the end of a completed cycle. A refused write leaves the latch unchanged.
- R11: While busy, every command except a status read is ignored. For example, code 3 leaves the latch set.
- R12: A status write takes the guard field from data bits 3:2. The old field stays visible until the cycle ends.
- R13: A write frame that carries no data byte starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip-select level, low while a frame is open |
| wp_n | input | 1 | Write-protect pin level, low blocks writes |
| cmd_valid | input | 1 | Command strobe from the front-end |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Start address of a page write |
| data_valid | input | 1 | Data byte strobe |
| data_in | input | 8 | Data byte |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| status | output | 8 | Status value (see R2) |
| busy | output | 1 | Programming cycle in progress |

## Verification
A latch or guard field in the wrong state shows up at the first frame that tests it. Either busy rises one clock after chip-select goes high when it should not, or it stays low when it should rise. Status bits 1 and 3:2 expose the stored values at once. A wrong page buffer or cycle counter shows up within the eight clocks after busy rises, as a wrong address, wrong data or wrong clock of an array strobe. A wrong count shows up as a busy period of the wrong length.

// File: rtl/eewp_pkg.sv
// Shared types for the EEPROM write guard: command codes, frame kinds,
// and the guard-region decode. Assumes the guard covers the top quarter
// or top half of the address space, judged from the two top address bits.
package eewp_pkg;

    typedef enum logic [2:0] {
        OP_READ  = 3'd0,
        OP_WRITE = 3'd1,
        OP_WREN  = 3'd2,
        OP_WRDI  = 3'd3,
        OP_RDSR  = 3'd4,
        OP_WRSR  = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        TX_NONE = 2'd0,
        TX_PAGE = 2'd1,
        TX_STAT = 2'd2
    } txn_e;

    // Returns 1 when an address with top bits top2 lies in the guarded region.
    function automatic logic in_guarded(input logic [1:0] guard, input logic [1:0] top2);
        case (guard)
            2'b00:   return 1'b0;
            2'b01:   return (top2 == 2'b11);
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/eewp_status_reg.sv
// Holds the write-enable latch and the block-guard field.
// Assumes clr_wel and set_wel never arrive together; clear wins if they do.
module eewp_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_wel,
    input  logic       clr_wel,
    input  logic       load_guard,
    input  logic [1:0] guard_in,
    output logic       wel,
    output logic [1:0] guard
);

    // Enable latch: set and clear by command, cleared at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel <= 1'b0;
        else if (clr_wel) wel <= 1'b0;
        else if (set_wel) wel <= 1'b1;
    end

    // Guard field: loaded only when a status write cycle completes.
    always_ff @(posedge clk) begin
        if (!rst_n)          guard <= 2'b00;
        else if (load_guard) guard <= guard_in;
    end

endmodule

// File: rtl/eewp_page_buf.sv
// One-page staging buffer with a per-byte loaded mask and a wrapping
// fill pointer. Assumes PAGE_BYTES is a power of two so the pointer
// wraps inside the page by plain overflow.
module eewp_page_buf #(
    parameter int PAGE_BYTES = 8,
    parameter int DATA_W     = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open,
    input  logic [OFF_W-1:0]  open_off,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);

    logic [DATA_W-1:0]     mem_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;
    logic [OFF_W-1:0]      ptr_q;

    // Fill pointer and loaded mask: restart on open, advance per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            vld_q <= '0;
        end else if (open) begin
            ptr_q <= open_off;
            vld_q <= '0;
        end else if (push) begin
            ptr_q        <= ptr_q + 1'b1;
            vld_q[ptr_q] <= 1'b1;
        end
    end

    // Byte storage: one register per page slot.
    for (genvar gi = 0; gi < PAGE_BYTES; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                               mem_q[gi] <= '0;
            else if (push && !open && ptr_q == OFF_W'(gi)) mem_q[gi] <= push_data;
        end
    end

    // Read side used by the cycle sequencer.
    assign rd_data   = mem_q[rd_idx];
    assign rd_valid  = vld_q[rd_idx];
    assign any_valid = |vld_q;

endmodule

// File: rtl/eewp_cycle_timer.sv
// Self-timed programming cycle: busy for CYC clocks after start, a finish
// pulse on the last busy clock, and a step index that counts busy clocks
// and saturates once its top bit is set. Assumes start only while idle.
module eewp_cycle_timer #(
    parameter int CYC   = 40,
    parameter int IDX_W = 4,
    localparam int CNT_W = $clog2(CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             finish,
    output logic [IDX_W-1:0] step
);

    logic [CNT_W-1:0] cnt_q;

    // Busy flag and remaining-clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(CYC - 1);
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // Step index: busy clock number, saturating at the top bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          step <= '0;
        else if (start && !busy)             step <= '0;
        else if (busy && !step[IDX_W-1])     step <= step + 1'b1;
    end

    assign finish = busy && (cnt_q == '0);

endmodule

// File: rtl/eeprom_wr_ctrl.sv
// Write guard and page programming controller for a byte-addressed
// non-volatile array. Takes decoded command and data strobes plus the
// chip-select and write-protect levels, qualifies each write frame, and
// on chip-select release runs a fixed-length cycle that streams the
// page buffer to the array. Assumes one command per chip-select frame,
// strobes only while cs_n is low, and PAGE_BYTES a power of two.
module eeprom_wr_ctrl #(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 8,
    parameter int CLK_KHZ    = 200000,
    parameter int WC_US      = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              data_valid,
    input  logic [7:0]        data_in,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    output logic [7:0]        status,
    output logic              busy
);
    import eewp_pkg::*;

    localparam int     OFF_W  = $clog2(PAGE_BYTES);
    localparam int     PAGE_W = ADDR_W - OFF_W;
    localparam int     WC_EFF = (WC_US > 10000) ? 10000 : WC_US;
    localparam longint RAW    = longint'(CLK_KHZ) * longint'(WC_EFF) / 1000;
    localparam int     CYC    = (RAW < PAGE_BYTES) ? PAGE_BYTES : int'(RAW);

    op_e               op;
    txn_e              txn_q;
    txn_e              kind_q;
    logic              cs_q, txn_ok_q, txn_abort_q, sr_loaded_q;
    logic [PAGE_W-1:0] page_q;
    logic [7:0]        sr_data_q;
    logic              wel, finish, start, has_data, cmd_go;
    logic [1:0]        guard;
    logic [OFF_W:0]    step;
    logic [7:0]        buf_rd_data;
    logic              buf_rd_valid, buf_any;

    assign op     = op_e'(cmd_op);
    assign cmd_go = cmd_valid && !cs_n && !busy;

    // Previous chip-select level for release detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    // Frame tracker: kind, qualification and write-protect abort flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txn_q       <= TX_NONE;
            txn_ok_q    <= 1'b0;
            txn_abort_q <= 1'b0;
            page_q      <= '0;
        end else if (cs_n && !cs_q) begin
            txn_q <= TX_NONE;
        end else if (cmd_go) begin
            txn_abort_q <= 1'b0;
            case (op)
                OP_WRITE: begin
                    txn_q    <= TX_PAGE;
                    txn_ok_q <= wel && wp_n &&
                                !in_guarded(guard, cmd_addr[ADDR_W-1 -: 2]);
                    page_q   <= cmd_addr[ADDR_W-1:OFF_W];
                end
                OP_WRSR: begin
                    txn_q    <= TX_STAT;
                    txn_ok_q <= wel && wp_n;
                end
                default: txn_q <= TX_NONE;
            endcase
        end else if (txn_q != TX_NONE && !cs_n && !wp_n) begin
            txn_abort_q <= 1'b1;
        end
    end

    // Status-write data byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_data_q   <= '0;
            sr_loaded_q <= 1'b0;
        end else if (cmd_go) begin
            sr_loaded_q <= 1'b0;
        end else if (data_valid && !cs_n && txn_q == TX_STAT) begin
            sr_data_q   <= data_in;
            sr_loaded_q <= 1'b1;
        end
    end

    assign has_data = (txn_q == TX_PAGE) ? buf_any : sr_loaded_q;
    assign start    = cs_n && !cs_q && (txn_q != TX_NONE) && txn_ok_q &&
                      !txn_abort_q && wp_n && has_data && !busy;

    // Kind of the running cycle, latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n)     kind_q <= TX_NONE;
        else if (start) kind_q <= txn_q;
    end

    eewp_status_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_wel   (cmd_go && op == OP_WREN),
        .clr_wel   ((cmd_go && op == OP_WRDI) || finish),
        .load_guard(finish && kind_q == TX_STAT),
        .guard_in  (sr_data_q[3:2]),
        .wel       (wel),
        .guard     (guard)
    );

    eewp_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(8)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .open     (cmd_go && op == OP_WRITE),
        .open_off (cmd_addr[OFF_W-1:0]),
        .push     (data_valid && !cs_n && txn_q == TX_PAGE && !busy),
        .push_data(data_in),
        .rd_idx   (step[OFF_W-1:0]),
        .rd_data  (buf_rd_data),
        .rd_valid (buf_rd_valid),
        .any_valid(buf_any)
    );

    eewp_cycle_timer #(.CYC(CYC), .IDX_W(OFF_W + 1)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .finish(finish),
        .step  (step)
    );

    assign arr_we    = busy && kind_q == TX_PAGE && !step[OFF_W] && buf_rd_valid;
    assign arr_addr  = {page_q, step[OFF_W-1:0]};
    assign arr_wdata = buf_rd_data;
    assign status    = {4'b0000, guard, wel, busy};

endmodule

// File: rtl/eewp_chk.sv
// Checker for eeprom_wr_ctrl, observing ports only; attached by bind.
module eewp_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wp_n,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [7:0]        status,
    input logic              busy
);

    p_we_inside_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    p_we_same_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> (arr_addr[ADDR_W-1:3] == $past(arr_addr[ADDR_W-1:3])));

    p_start_after_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cs_n) && !$past(cs_n, 2)));

    p_start_needs_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(status[1]));

    p_start_needs_wp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wp_n));

    p_latch_clear_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !status[1]);

    p_guard_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(status[3:2]));

endmodule

bind eeprom_wr_ctrl eewp_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wp_n    (wp_n),
    .arr_we  (arr_we),
    .arr_addr(arr_addr),
    .status  (status),
    .busy    (busy)
);

// File: tb/tb_eeprom_wr_ctrl.sv
module tb_eeprom_wr_ctrl;
    import eewp_pkg::*;

    localparam int EXP_CYC = 40; // 4 kHz units * min(20000,10000) us / 1000

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wp_n = 1'b1, cmd_valid = 1'b0, data_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [8:0] cmd_addr = '0;
    logic [7:0] data_in = '0;
    logic       arr_we, busy;
    logic [8:0] arr_addr;
    logic [7:0] arr_wdata, status;

    int total = 0, bad = 0, wn = 0, busy_cnt = 0;
    logic [8:0] lg_addr [16];
    logic [7:0] lg_data [16];
    int         lg_cyc  [16];
    bit         done = 0;

    always #2.5 clk = ~clk;

    eeprom_wr_ctrl #(.ADDR_W(9), .PAGE_BYTES(8), .CLK_KHZ(4), .WC_US(20000)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .data_valid(data_valid), .data_in(data_in),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .status(status), .busy(busy)
    );

    // Array write and busy-length monitor.
    always @(negedge clk) begin
        if (arr_we) begin
            if (wn < 16) begin
                lg_addr[wn] = arr_addr;
                lg_data[wn] = arr_wdata;
                lg_cyc[wn]  = busy_cnt;
            end
            wn = wn + 1;
        end
        if (busy) busy_cnt = busy_cnt + 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_cmd(input op_e op, input logic [8:0] a);
        cs_n = 1'b0; cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        data_valid = 1'b1; data_in = d;
        tick();
        data_valid = 1'b0;
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        tick();
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 200 && busy; n++) tick();
        tick();
    endtask

    task automatic clear_log();
        wn = 0; busy_cnt = 0;
    endtask

    task automatic set_guard(input logic [1:0] g);
        wp_n = 1'b1;
        send_cmd(OP_WREN, '0); end_frame();
        send_cmd(OP_WRSR, '0); send_byte({4'b0, g, 2'b00}); end_frame();
        wait_idle();
    endtask

    // {guard[2], wren, wp, addr[9], nbytes[4], expected writes[4]}
    localparam logic [20:0] VECS [9] = '{
        {2'd0, 1'b1, 1'b1, 9'h005, 4'd3, 4'd3},  // R6 R7 plain write
        {2'd0, 1'b0, 1'b1, 9'h010, 4'd2, 4'd0},  // R3 latch clear
        {2'd0, 1'b1, 1'b0, 9'h010, 4'd2, 4'd0},  // R4 wp low
        {2'd1, 1'b1, 1'b1, 9'h180, 4'd2, 4'd0},  // R5 quarter blocked
        {2'd1, 1'b1, 1'b1, 9'h17F, 4'd1, 4'd1},  // R5 just below quarter
        {2'd2, 1'b1, 1'b1, 9'h100, 4'd1, 4'd0},  // R5 half blocked
        {2'd2, 1'b1, 1'b1, 9'h0FF, 4'd1, 4'd1},  // R5 just below half
        {2'd3, 1'b1, 1'b1, 9'h000, 4'd1, 4'd0},  // R5 all blocked
        {2'd0, 1'b1, 1'b1, 9'h1FF, 4'd1, 4'd1}   // R5 top byte open
    };

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1", "status after reset", status, 0);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "arr_we after reset", arr_we, 0);

        // R2: latch set and clear by command
        send_cmd(OP_WREN, '0); end_frame();
        chk("R2", "status after set-latch", status, 8'h02);
        send_cmd(OP_WRDI, '0); end_frame();
        chk("R2", "status after clear-latch", status, 8'h00);

        // Table walk
        for (int v = 0; v < 9; v++) begin
            logic [20:0] e;
            logic [8:0]  a;
            int          nb, ex;
            e = VECS[v]; a = e[16:8]; nb = int'(e[7:4]); ex = int'(e[3:0]);
            set_guard(e[20:19]);
            chk("R12", $sformatf("v%0d guard field", v), status[3:2], e[20:19]);
            if (e[18]) begin send_cmd(OP_WREN, '0); end_frame(); end
            clear_log();
            wp_n = e[17];
            send_cmd(OP_WRITE, a);
            for (int k = 0; k < nb; k++) send_byte(8'(v * 16 + k + 8'h3C));
            end_frame();
            wait_idle();
            wp_n = 1'b1;
            chk("R3 R4 R5", $sformatf("v%0d array writes", v), wn, ex);
            chk("R7", $sformatf("v%0d busy clocks", v), busy_cnt, (ex != 0) ? EXP_CYC : 0);
            chk("R10", $sformatf("v%0d latch after", v), status[1], (e[18] && ex == 0) ? 1 : 0);
            for (int i = 0; i < ex && i < 16; i++) begin
                chk("R6", $sformatf("v%0d addr %0d", v, i), lg_addr[i], a + 9'(i));
                chk("R6", $sformatf("v%0d data %0d", v, i), lg_data[i], 8'(v * 16 + i + 8'h3C));
            end
        end

        // R6: rollover inside page, ascending order, one per clock
        set_guard(2'b00);
        send_cmd(OP_WREN, '0); end_frame();
        clear_log();
        send_cmd(OP_WRITE, 9'h0A6);
        for (int k = 0; k < 10; k++) send_byte(8'hA0 + 8'(k));
        end_frame();
        chk("R7", "busy one clock after release", busy, 1);
        chk("R2", "status busy bit", status[0], 1);
        wait_idle();
        chk("R6", "rollover write count", wn, 8);
        for (int o = 0; o < 8; o++) begin
            chk("R6", $sformatf("rollover addr %0d", o), lg_addr[o], 9'h0A0 + 9'(o));
            chk("R6", $sformatf("rollover data %0d", o), lg_data[o], 8'hA2 + 8'(o));
            chk("R6", $sformatf("rollover clock %0d", o), lg_cyc[o], o);
        end

        // R8: wp pulse inside open frame abandons it
        send_cmd(OP_WREN, '0); end_frame();
        clear_log();
        send_cmd(OP_WRITE, 9'h020);
        send_byte(8'h11);
        wp_n = 1'b0; tick(); wp_n = 1'b1;
        send_byte(8'h22);
        end_frame();
        repeat (3) tick();
        chk("R8", "busy after aborted frame", busy, 0);
        chk("R8", "writes after aborted frame", wn, 0);
        chk("R10", "latch kept after abort", status[1], 1);

        // R9: wp low after start has no effect
        clear_log();
        send_cmd(OP_WRITE, 9'h020);
        send_byte(8'h33); send_byte(8'h44);
        end_frame();
        wp_n = 1'b0;
        wait_idle();
        wp_n = 1'b1;
        chk("R9", "writes with wp low mid-cycle", wn, 2);
        chk("R9", "busy length with wp low", busy_cnt, EXP_CYC);

        // R11: clear-latch while busy is ignored
        send_cmd(OP_WREN, '0); end_frame();
        send_cmd(OP_WRITE, 9'h040); send_byte(8'h55); end_frame();
        send_cmd(OP_WRDI, '0); end_frame();
        chk("R11", "latch while busy", status[1], 1);
        chk("R11", "still busy", busy, 1);
        wait_idle();
        chk("R10", "latch after cycle", status[1], 0);

        // R4: status write blocked by wp low
        send_cmd(OP_WREN, '0); end_frame();
        wp_n = 1'b0;
        send_cmd(OP_WRSR, '0); send_byte(8'h0C); end_frame();
        tick();
        wp_n = 1'b1;
        chk("R4", "no cycle for status write", busy, 0);
        chk("R4", "guard unchanged", status[3:2], 0);

        // R12: new guard appears only at cycle end
        send_cmd(OP_WRSR, '0); send_byte(8'h08); end_frame();
        chk("R12", "old guard while busy", status, 8'h03);
        wait_idle();
        chk("R12", "status after status write", status, 8'h08);

        // R13: write frame with no data
        set_guard(2'b00);
        send_cmd(OP_WREN, '0); end_frame();
        clear_log();
        send_cmd(OP_WRITE, 9'h050); end_frame();
        tick();
        chk("R13", "busy without data", busy, 0);
        chk("R13", "latch kept without data", status[1], 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule